// File: doc/BRIEF.md
# Two-wire controller register bank

This block is the software-visible register file of a two-wire serial controller. It sits on a simple 16-bit peripheral bus (select, write enable, access size, byte address, write data, read data, error strobe) and holds the configuration words that the serial engine consumes: clock divider, control, slave and master control and address, interrupt mask and FIFO control. It also holds two sticky status words that hardware sets through pulse inputs and software clears by writing ones, and it mirrors three read-only status words supplied by the engine.

Two data ports complete the map. A transmit holding register can be loaded through a byte-wide alias (upper byte forced to zero) or a full 16-bit alias. Each load raises a one-cycle strobe toward the engine. A receive word supplied from outside reads back through two aliases. Every access that is not a 16-bit access to a mapped, aligned offset raises the error strobe in the same cycle and changes nothing.

Top module: `twi_regbank`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`) every stored register is zero: all mapped registers read 0, `tx_data` is 0, `tx_wr_pulse` and `irq` are 0.
- R2: The words at offsets 0x00 (clock divider), 0x04 (control), 0x08 (slave control), 0x10 (slave address), 0x14 (master control), 0x1C (master address), 0x24 (interrupt mask) and 0x28 (FIFO control) store the full 16-bit write value and read it back.
- R3: Each of those eight words drives its own `cfg_*` output with the stored value from the cycle after the write.
- R4: Interrupt status (0x20) sets bit i on the cycle after `int_set[i]` is high; a write clears each bit where the write data is one and leaves the others; a set wins over a same-cycle clear.
- R5: Master status (0x18) holds sticky flags at bits 2..6 (bit 2 lost arbitration, bit 3 address NAK, bit 4 data NAK, bit 5 buffer read error, bit 6 buffer write error), set by `mst_flag_set[0..4]` in that order and cleared only by writing one to the flag's bit; a set wins over a same-cycle clear. All other bits show `mst_live_in` as sampled on the previous edge and ignore writes.
- R6: Slave status (0x0C) and FIFO status (0x2C) read `slv_stat_in` and `fifo_stat_in` as sampled on the previous edge; writes to them and to the receive ports are accepted without error and have no effect.
- R7: A write to the 8-bit transmit port (0x80) loads `tx_data` with the low byte and a zero upper byte; a write to the 16-bit transmit port (0x84) loads all 16 bits into the same register.
- R8: `tx_wr_pulse` is high for exactly the one cycle that follows each accepted transmit-port write.
- R9: Reads of 0x80 and 0x84 return zero; reads of 0x88 and 0x8C return `rx_data`.
- R10: Access size is encoded on `bus_size` as 0 byte, 1 half-word, 2 word, 3 reserved. While `bus_sel` is high, `bus_err` is high in the same cycle when the size is not 1 or the offset is misaligned or unmapped; such an access changes no state and reads 0.
- R11: `irq` is high whenever interrupt status AND interrupt mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle, 0 when not a legal read |
| bus_err | output | 1 | Illegal access strobe |
| rx_data | input | 16 | Receive word from the engine |
| tx_data | output | 16 | Transmit holding register |
| tx_wr_pulse | output | 1 | One-cycle strobe after a transmit load |
| slv_stat_in | input | 16 | Slave status from the engine |
| fifo_stat_in | input | 16 | FIFO status from the engine |
| mst_live_in | input | 16 | Non-sticky master status bits |
| mst_flag_set | input | 5 | Set pulses for the sticky master flags |
| int_set | input | 16 | Per-bit interrupt status set pulses |
| irq | output | 1 | Masked interrupt request |
| cfg_clkdiv | output | 16 | Clock divider word |
| cfg_ctrl | output | 16 | Control word |
| cfg_slv_ctl | output | 16 | Slave control word |
| cfg_slv_addr | output | 16 | Slave address word |
| cfg_mst_ctl | output | 16 | Master control word |
| cfg_mst_addr | output | 16 | Master address word |
| cfg_int_mask | output | 16 | Interrupt mask word |
| cfg_fifo_ctl | output | 16 | FIFO control word |

## Verification
The bench aims at the places where access types meet: a set pulse and a clearing write on the same bit in the same cycle (a design with the wrong priority loses the event), a write of all ones to master status (a design with a full-width clear mask wipes the live bits or leaves a flag stuck), and a byte-alias transmit write with a nonzero upper byte (a design that forgets the truncation leaks it onto `tx_data`). It also issues byte, word and reserved-size accesses, misaligned and gap offsets, and writes to read-only words, then reads the targets back; a design that stored on an erroring access or on a read-only write would return a changed word, and one that decoded only part of the address would answer in the gap instead of raising the error.

// File: rtl/twi_regbank_pkg.sv
// Shared types and constants for the two-wire controller register bank.
// Assumes: 16-bit peripheral bus with byte offsets on a 4-byte stride.
package twi_regbank_pkg;

    // Access size code on the bus.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Register identity; numeric order follows the word order of the map.
    typedef enum logic [4:0] {
        ID_CLKDIV    = 5'd0,
        ID_CONTROL   = 5'd1,
        ID_SLV_CTL   = 5'd2,
        ID_SLV_STAT  = 5'd3,
        ID_SLV_ADDR  = 5'd4,
        ID_MST_CTL   = 5'd5,
        ID_MST_STAT  = 5'd6,
        ID_MST_ADDR  = 5'd7,
        ID_INT_STAT  = 5'd8,
        ID_INT_MASK  = 5'd9,
        ID_FIFO_CTL  = 5'd10,
        ID_FIFO_STAT = 5'd11,
        ID_TX8       = 5'd12,
        ID_TX16      = 5'd13,
        ID_RX8       = 5'd14,
        ID_RX16      = 5'd15,
        ID_NONE      = 5'd31
    } reg_id_e;

    localparam int NUM_MAPPED     = 16;
    localparam int NUM_CTRL_WORDS = 12;
    localparam int DATA_PORT_WORD = 32;   // first data port word index
    localparam int NUM_CFG        = 8;

    // Slots of the plain read/write configuration words.
    localparam int CFG_CLKDIV   = 0;
    localparam int CFG_CONTROL  = 1;
    localparam int CFG_SLV_CTL  = 2;
    localparam int CFG_SLV_ADDR = 3;
    localparam int CFG_MST_CTL  = 4;
    localparam int CFG_MST_ADDR = 5;
    localparam int CFG_INT_MASK = 6;
    localparam int CFG_FIFO_CTL = 7;

    // Sticky master flags: lost arbitration, address NAK, data NAK,
    // buffer read error, buffer write error from this bit upward.
    localparam int FLAG_LSB  = 2;
    localparam int NUM_FLAGS = 5;

    // Word index of register number k.
    function automatic int word_of(input int k);
        return (k < NUM_CTRL_WORDS) ? k : DATA_PORT_WORD + (k - NUM_CTRL_WORDS);
    endfunction

    // Configuration slot of a register, -1 when it is not a plain word.
    function automatic int cfg_slot_of(input reg_id_e id);
        case (id)
            ID_CLKDIV:   return CFG_CLKDIV;
            ID_CONTROL:  return CFG_CONTROL;
            ID_SLV_CTL:  return CFG_SLV_CTL;
            ID_SLV_ADDR: return CFG_SLV_ADDR;
            ID_MST_CTL:  return CFG_MST_CTL;
            ID_MST_ADDR: return CFG_MST_ADDR;
            ID_INT_MASK: return CFG_INT_MASK;
            ID_FIFO_CTL: return CFG_FIFO_CTL;
            default:     return -1;
        endcase
    endfunction

endpackage

// File: rtl/twi_addr_decode.sv
// Address and size decoder.
// Maps a byte offset to a register identity and flags illegal accesses.
// Assumes: offsets must be 4-byte aligned; only half-word size is legal.
module twi_addr_decode
    import twi_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_id_e           hit_id,
    output logic              acc_ok,
    output logic              acc_err
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    // Find the register whose word index matches the offset.
    always_comb begin
        hit_id = ID_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            for (int k = 0; k < NUM_MAPPED; k++) begin
                if (int'(widx) == word_of(k)) hit_id = reg_id_e'(5'(k));
            end
        end
    end

    // Legal only for a half-word access to a mapped register.
    always_comb begin
        acc_ok  = bus_sel && (bus_size == SZ_HALF) && (hit_id != ID_NONE);
        acc_err = bus_sel && !acc_ok;
    end
endmodule

// File: rtl/twi_cfg_bank.sv
// Bank of plain read/write configuration words.
// Each slot stores the full write value when its write enable is high.
// Assumes: at most one write enable is high per cycle.
module twi_cfg_bank #(
    parameter int DATA_W = 16,
    parameter int NUM    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM-1:0]              wr_en,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        // Hold one configuration word; load on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[g] <= '0;
            else if (wr_en[g]) q[g] <= wdata;
        end
    end
endmodule

// File: rtl/twi_sticky_status.sv
// Status word mixing sticky write-one-to-clear bits with live bits.
// Bits in CLR_MASK are set by set_bits and cleared by a clearing write;
// a set wins over a same-cycle clear. Other bits follow live_bits.
// Assumes: set_bits outside CLR_MASK are zero.
module twi_sticky_status #(
    parameter int               DATA_W   = 16,
    parameter logic [DATA_W-1:0] CLR_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] live_bits,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] nxt;

    // Form the next word from sticky and live parts.
    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
        nxt     = (((q & ~clr_vec) | set_bits) & CLR_MASK)
                | (live_bits & ~CLR_MASK);
    end

    // Register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/twi_tx_hold.sv
// Transmit holding register with byte and half-word load aliases.
// A byte load zeroes the upper bits; every load raises a one-cycle strobe.
// Assumes: the two loads are never high together.
module twi_tx_hold #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic              wr_full,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data,
    output logic              pulse
);
    // Load the holding register and mark the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= wr_byte | wr_full;
            if (wr_full)      data <= wdata;
            else if (wr_byte) data <= DATA_W'(wdata[BYTE_W-1:0]);
        end
    end
endmodule

// File: rtl/twi_regbank.sv
// Register bank of a two-wire serial controller on a 16-bit peripheral bus.
// Holds configuration words, sticky status words, mirrored engine status
// and the transmit/receive data ports. Reads are combinational.
// Assumes: synchronous active-low reset; one access per cycle.
module twi_regbank
    import twi_regbank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_wr_pulse,
    input  logic [DATA_W-1:0] slv_stat_in,
    input  logic [DATA_W-1:0] fifo_stat_in,
    input  logic [DATA_W-1:0] mst_live_in,
    input  logic [4:0]        mst_flag_set,
    input  logic [DATA_W-1:0] int_set,
    output logic              irq,
    output logic [DATA_W-1:0] cfg_clkdiv,
    output logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] cfg_slv_ctl,
    output logic [DATA_W-1:0] cfg_slv_addr,
    output logic [DATA_W-1:0] cfg_mst_ctl,
    output logic [DATA_W-1:0] cfg_mst_addr,
    output logic [DATA_W-1:0] cfg_int_mask,
    output logic [DATA_W-1:0] cfg_fifo_ctl
);
    localparam int BYTE_W = 8;
    localparam logic [DATA_W-1:0] MST_FLAG_MASK =
        DATA_W'(((1 << NUM_FLAGS) - 1) << FLAG_LSB);

    reg_id_e                        hit_id;
    logic                           acc_ok;
    logic                           wr_ok;
    logic [NUM_CFG-1:0]             cfg_wr;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0]              istat_q;
    logic [DATA_W-1:0]              mstat_q;
    logic [DATA_W-1:0]              slv_stat_q;
    logic [DATA_W-1:0]              fifo_stat_q;
    logic [DATA_W-1:0]              mst_set_vec;
    logic [DATA_W-1:0]              rd_word;

    twi_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .hit_id   (hit_id),
        .acc_ok   (acc_ok),
        .acc_err  (bus_err)
    );

    assign wr_ok = acc_ok && bus_we;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_wr
        assign cfg_wr[g] = wr_ok && (cfg_slot_of(hit_id) == g);
    end

    twi_cfg_bank #(.DATA_W(DATA_W), .NUM(NUM_CFG)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (bus_wdata),
        .q     (cfg_q)
    );

    twi_sticky_status #(.DATA_W(DATA_W), .CLR_MASK({DATA_W{1'b1}})) u_istat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (wr_ok && (hit_id == ID_INT_STAT)),
        .clr_bits  (bus_wdata),
        .set_bits  (int_set),
        .live_bits ('0),
        .q         (istat_q)
    );

    assign mst_set_vec = DATA_W'(mst_flag_set) << FLAG_LSB;

    twi_sticky_status #(.DATA_W(DATA_W), .CLR_MASK(MST_FLAG_MASK)) u_mstat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (wr_ok && (hit_id == ID_MST_STAT)),
        .clr_bits  (bus_wdata),
        .set_bits  (mst_set_vec),
        .live_bits (mst_live_in),
        .q         (mstat_q)
    );

    twi_tx_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_byte (wr_ok && (hit_id == ID_TX8)),
        .wr_full (wr_ok && (hit_id == ID_TX16)),
        .wdata   (bus_wdata),
        .data    (tx_data),
        .pulse   (tx_wr_pulse)
    );

    // Sample the engine's read-only status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slv_stat_q  <= '0;
            fifo_stat_q <= '0;
        end else begin
            slv_stat_q  <= slv_stat_in;
            fifo_stat_q <= fifo_stat_in;
        end
    end

    // Select the word addressed by a read.
    always_comb begin
        case (hit_id)
            ID_CLKDIV:    rd_word = cfg_q[CFG_CLKDIV];
            ID_CONTROL:   rd_word = cfg_q[CFG_CONTROL];
            ID_SLV_CTL:   rd_word = cfg_q[CFG_SLV_CTL];
            ID_SLV_STAT:  rd_word = slv_stat_q;
            ID_SLV_ADDR:  rd_word = cfg_q[CFG_SLV_ADDR];
            ID_MST_CTL:   rd_word = cfg_q[CFG_MST_CTL];
            ID_MST_STAT:  rd_word = mstat_q;
            ID_MST_ADDR:  rd_word = cfg_q[CFG_MST_ADDR];
            ID_INT_STAT:  rd_word = istat_q;
            ID_INT_MASK:  rd_word = cfg_q[CFG_INT_MASK];
            ID_FIFO_CTL:  rd_word = cfg_q[CFG_FIFO_CTL];
            ID_FIFO_STAT: rd_word = fifo_stat_q;
            ID_RX8,
            ID_RX16:      rd_word = rx_data;
            default:      rd_word = '0;   // transmit ports and no hit
        endcase
    end

    // Drive read data only for a legal read.
    always_comb begin
        bus_rdata = (acc_ok && !bus_we) ? rd_word : '0;
    end

    // Raise the request while any unmasked status bit is set.
    always_comb begin
        irq = |(istat_q & cfg_q[CFG_INT_MASK]);
    end

    assign cfg_clkdiv   = cfg_q[CFG_CLKDIV];
    assign cfg_ctrl     = cfg_q[CFG_CONTROL];
    assign cfg_slv_ctl  = cfg_q[CFG_SLV_CTL];
    assign cfg_slv_addr = cfg_q[CFG_SLV_ADDR];
    assign cfg_mst_ctl  = cfg_q[CFG_MST_CTL];
    assign cfg_mst_addr = cfg_q[CFG_MST_ADDR];
    assign cfg_int_mask = cfg_q[CFG_INT_MASK];
    assign cfg_fifo_ctl = cfg_q[CFG_FIFO_CTL];
endmodule

// File: rtl/twi_regbank_chk.sv
// Property checker for the register bank, bound to every instance.
// Assumes: size code 1 is the only legal size; map offsets as in the brief.
module twi_regbank_chk
    import twi_regbank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_wr_pulse,
    input logic [DATA_W-1:0] int_set,
    input logic [4:0]        mst_flag_set,
    input logic [DATA_W-1:0] istat_q,
    input logic [DATA_W-1:0] mstat_q
);
    localparam logic [ADDR_W-1:0] A_TX8  = ADDR_W'(word_of(int'(ID_TX8)) * 4);
    localparam logic [ADDR_W-1:0] A_TX16 = ADDR_W'(word_of(int'(ID_TX16)) * 4);

    logic tx_hit;
    assign tx_hit = bus_sel && !bus_err && (bus_addr == A_TX8 || bus_addr == A_TX16);

    p_bad_size_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size != 2'd1) |-> bus_err);

    p_err_no_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_err) |=> !tx_wr_pulse);

    p_tx_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hit && !bus_we) |-> (bus_rdata == '0));

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hit && bus_we) |=> tx_wr_pulse);

    p_tx8_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hit && bus_we && bus_addr == A_TX8) |=> (tx_data[DATA_W-1:8] == '0));

    p_istat_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_set) |=> ((istat_q & $past(int_set)) == $past(int_set)));

    p_mflag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mst_flag_set) |=>
            ((mstat_q[FLAG_LSB +: NUM_FLAGS] & $past(mst_flag_set)) == $past(mst_flag_set)));
endmodule

bind twi_regbank twi_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .tx_data      (tx_data),
    .tx_wr_pulse  (tx_wr_pulse),
    .int_set      (int_set),
    .mst_flag_set (mst_flag_set),
    .istat_q      (istat_q),
    .mstat_q      (mstat_q)
);

// File: tb/twi_regbank_test.sv
// Scoreboard bench: access tasks queue expected bus results, a monitor
// compares them mid-cycle; port-level results are checked directly.
module twi_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [15:0] rx_data = '0;
    logic [15:0] tx_data;
    logic        tx_wr_pulse;
    logic [15:0] slv_stat_in = '0;
    logic [15:0] fifo_stat_in = '0;
    logic [15:0] mst_live_in = '0;
    logic [4:0]  mst_flag_set = '0;
    logic [15:0] int_set = '0;
    logic        irq;
    logic [15:0] cfg_clkdiv, cfg_ctrl, cfg_slv_ctl, cfg_slv_addr;
    logic [15:0] cfg_mst_ctl, cfg_mst_addr, cfg_int_mask, cfg_fifo_ctl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic        exp_err;
        logic        chk_rd;
        logic [15:0] exp_rd;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    twi_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_data(rx_data),
        .tx_data(tx_data), .tx_wr_pulse(tx_wr_pulse),
        .slv_stat_in(slv_stat_in), .fifo_stat_in(fifo_stat_in),
        .mst_live_in(mst_live_in), .mst_flag_set(mst_flag_set),
        .int_set(int_set), .irq(irq),
        .cfg_clkdiv(cfg_clkdiv), .cfg_ctrl(cfg_ctrl), .cfg_slv_ctl(cfg_slv_ctl),
        .cfg_slv_addr(cfg_slv_addr), .cfg_mst_ctl(cfg_mst_ctl),
        .cfg_mst_addr(cfg_mst_addr), .cfg_int_mask(cfg_int_mask),
        .cfg_fifo_ctl(cfg_fifo_ctl)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each bus access against the queued expectation.
    always @(negedge clk) begin
        if (bus_sel && rst_n) begin
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual access expected none");
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " err"}, 16'(bus_err), 16'(it.exp_err));
                if (it.chk_rd) check({it.tag, " rdata"}, bus_rdata, it.exp_rd);
            end
        end
    end

    task automatic acc(input bit we, input logic [7:0] a, input logic [1:0] sz,
                       input logic [15:0] wd, input bit eerr, input bit chk,
                       input logic [15:0] erd, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        int_set = '0; mst_flag_set = '0;
        it.exp_err = eerr; it.chk_rd = chk; it.exp_rd = erd; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        acc(1'b1, a, 2'd1, d, 1'b0, 1'b0, 16'h0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        acc(1'b0, a, 2'd1, 16'h0, 1'b0, 1'b1, e, tag);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; int_set = '0; mst_flag_set = '0;
    endtask

    // Check ports in the middle of the current cycle.
    task automatic mid();
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        mid();
        check("R1 tx_data", tx_data, 16'h0);
        check("R1 tx_wr_pulse", 16'(tx_wr_pulse), 16'h0);
        check("R1 irq", 16'(irq), 16'h0);
        for (int k = 0; k < 12; k++) rd(8'(k * 4), 16'h0, "R1 reset read");
        rd(8'h80, 16'h0, "R1 tx8"); rd(8'h88, 16'h0, "R1 rx8");

        // R2: plain words store full value
        wr(8'h00, 16'h1F0A, "R2 clkdiv");  wr(8'h04, 16'h0081, "R2 ctrl");
        wr(8'h08, 16'h5A5A, "R2 slvctl");  wr(8'h10, 16'h0042, "R2 slvaddr");
        wr(8'h14, 16'hA5C3, "R2 mstctl");  wr(8'h1C, 16'h0077, "R2 mstaddr");
        wr(8'h24, 16'hFFFF, "R2 imask");   wr(8'h28, 16'h0003, "R2 fifoctl");
        rd(8'h00, 16'h1F0A, "R2 clkdiv");  rd(8'h04, 16'h0081, "R2 ctrl");
        rd(8'h08, 16'h5A5A, "R2 slvctl");  rd(8'h10, 16'h0042, "R2 slvaddr");
        rd(8'h14, 16'hA5C3, "R2 mstctl");  rd(8'h1C, 16'h0077, "R2 mstaddr");
        rd(8'h24, 16'hFFFF, "R2 imask");   rd(8'h28, 16'h0003, "R2 fifoctl");
        idle(); mid();
        // R3: configuration outputs
        check("R3 clkdiv", cfg_clkdiv, 16'h1F0A);  check("R3 ctrl", cfg_ctrl, 16'h0081);
        check("R3 slvctl", cfg_slv_ctl, 16'h5A5A); check("R3 slvaddr", cfg_slv_addr, 16'h0042);
        check("R3 mstctl", cfg_mst_ctl, 16'hA5C3); check("R3 mstaddr", cfg_mst_addr, 16'h0077);
        check("R3 imask", cfg_int_mask, 16'hFFFF); check("R3 fifoctl", cfg_fifo_ctl, 16'h0003);
        check("R11 irq masked-in but no status", 16'(irq), 16'h0);

        // R6: read-only words and receive ports
        slv_stat_in = 16'h1234; fifo_stat_in = 16'h00F0; rx_data = 16'hBEEF;
        idle();
        rd(8'h0C, 16'h1234, "R6 slvstat"); rd(8'h2C, 16'h00F0, "R6 fifostat");
        wr(8'h0C, 16'hFFFF, "R6 slvstat write"); wr(8'h2C, 16'hFFFF, "R6 fifostat write");
        wr(8'h88, 16'h0000, "R6 rx8 write");     wr(8'h8C, 16'h0000, "R6 rx16 write");
        rd(8'h0C, 16'h1234, "R6 slvstat kept"); rd(8'h2C, 16'h00F0, "R6 fifostat kept");
        // R9: receive ports read rx_data
        rd(8'h88, 16'hBEEF, "R9 rx8"); rd(8'h8C, 16'hBEEF, "R9 rx16");

        // R7, R8, R9: transmit ports
        wr(8'h84, 16'hCAFE, "R7 tx16 write");
        idle(); mid();
        check("R7 tx16 data", tx_data, 16'hCAFE);
        check("R8 pulse after tx16", 16'(tx_wr_pulse), 16'h1);
        idle(); mid();
        check("R8 pulse single cycle", 16'(tx_wr_pulse), 16'h0);
        rd(8'h84, 16'h0, "R9 tx16 reads zero"); rd(8'h80, 16'h0, "R9 tx8 reads zero");
        wr(8'h80, 16'h12AB, "R7 tx8 write");
        idle(); mid();
        check("R7 tx8 upper byte zeroed", tx_data, 16'h00AB);
        check("R8 pulse after tx8", 16'(tx_wr_pulse), 16'h1);

        // R4, R11: interrupt status
        @(posedge clk); #1 int_set = 16'h8181;
        idle();
        rd(8'h20, 16'h8181, "R4 set pulses");
        idle(); mid();
        check("R11 irq with full mask", 16'(irq), 16'h1);
        wr(8'h20, 16'h0180, "R4 partial clear");
        rd(8'h20, 16'h8001, "R4 partial clear");
        wr(8'h24, 16'h0001, "R11 mask bit0");
        idle(); mid();
        check("R11 irq unmasked bit", 16'(irq), 16'h1);
        wr(8'h24, 16'h0100, "R11 mask bit8");
        idle(); mid();
        check("R11 irq masked off", 16'(irq), 16'h0);
        wr(8'h20, 16'h0100, "R4 clear with set");
        int_set = 16'h0100;
        idle(); mid();
        check("R11 irq after set-over-clear", 16'(irq), 16'h1);
        rd(8'h20, 16'h8101, "R4 set wins over clear");
        wr(8'h20, 16'hFFFF, "R4 clear all");
        rd(8'h20, 16'h0000, "R4 clear all");
        idle(); mid();
        check("R11 irq after clear", 16'(irq), 16'h0);

        // R5: master status
        mst_live_in = 16'hFF83;
        idle();
        rd(8'h18, 16'hFF83, "R5 live bits");
        @(posedge clk); #1 bus_sel = 1'b0; mst_flag_set = 5'b10101;
        idle();
        rd(8'h18, 16'hFFD7, "R5 flags set bits 2 4 6");
        wr(8'h18, 16'h0010, "R5 clear data NAK");
        rd(8'h18, 16'hFFC7, "R5 clear data NAK");
        wr(8'h18, 16'hFFFF, "R5 write all ones");
        rd(8'h18, 16'hFF83, "R5 live bits ignore write");
        wr(8'h18, 16'h0008, "R5 clear with set");
        mst_flag_set = 5'b00010;
        idle();
        rd(8'h18, 16'hFF8B, "R5 set wins over clear");

        // R10: illegal accesses
        acc(1'b0, 8'h00, 2'd0, 16'h0, 1'b1, 1'b1, 16'h0, "R10 byte read");
        acc(1'b1, 8'h00, 2'd2, 16'h0000, 1'b1, 1'b0, 16'h0, "R10 word write");
        acc(1'b1, 8'h00, 2'd3, 16'h0000, 1'b1, 1'b0, 16'h0, "R10 reserved size write");
        rd(8'h00, 16'h1F0A, "R10 clkdiv unchanged");
        acc(1'b0, 8'h30, 2'd1, 16'h0, 1'b1, 1'b1, 16'h0, "R10 gap offset");
        acc(1'b0, 8'h02, 2'd1, 16'h0, 1'b1, 1'b1, 16'h0, "R10 misaligned");
        acc(1'b0, 8'h90, 2'd1, 16'h0, 1'b1, 1'b1, 16'h0, "R10 past end");
        acc(1'b1, 8'h7C, 2'd1, 16'hFFFF, 1'b1, 1'b0, 16'h0, "R10 write in gap");
        acc(1'b1, 8'h84, 2'd0, 16'h5555, 1'b1, 1'b0, 16'h0, "R10 tx byte-size write");
        idle(); mid();
        check("R10 tx_data unchanged", tx_data, 16'h00AB);
        check("R10 no tx pulse", 16'(tx_wr_pulse), 16'h0);

        idle(); idle();
        check("R1 scoreboard drained", 16'(sb.size()), 16'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule